// File: doc/BRIEF.md
# Serial Configuration Loader

The loader is the device-side controller that fetches a configuration bitstream from a chain of external configuration memories. It makes the memory clock itself by dividing the system clock. It holds `init_o` as the memory address reset before every load. It then clocks in one bit, or one byte, per configuration clock edge until a programmed length is reached. At the end it raises `done_o`, which is wired to the memory chip enable, so the memories release the shared data lines.

The mode is read from three mode pins when the init phase ends. A program request restarts the whole sequence at any time. Received data leaves the block as single-cycle valid/data pulses. Parsing, CRC checking and applying the configuration belong to the consumer of that stream.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_ni` is low, `init_o` is 1 and `done_o`, `err_o`, `cfg_clk_o` and `out_valid_o` are 0. After reset the loader enters the init phase without further stimulus.
- R2: `mode_i` is sampled on the last cycle of the init phase. 3'b000 selects serial loading and 3'b011 selects byte-wide loading. Any other code enters an error state: `err_o` is 1, `done_o` and `init_o` are 0, and no configuration clock is produced until the next program request.
- R3: `init_o` is 1 from reset, for as long as `prog_req_i` is 1, and for at least INIT_CYC system cycles after that. `cfg_clk_o` is 0 whenever `init_o` is 1, so the external memory address counter returns to 0 before every load.
- R4: During loading, each high phase and each low phase of `cfg_clk_o` lasts exactly DIV_HALF system cycles. The one exception is a phase cut short by a program request. Outside loading, `cfg_clk_o` is 0.
- R5: In serial mode, `din_i[0]` is captured in the system cycle in which `cfg_clk_o` rises. `out_valid_o` pulses for one cycle together with that rise, with the bit in `out_data_o[0]` and the upper bits at 0.
- R6: In byte-wide mode, the full `din_i` byte is captured on each rise. The number of clock pulses is ceil(`bit_len_i`/8).
- R7: In serial mode, exactly `bit_len_i` rising edges are issued per load. `bit_len_i` is sampled at the end of the init phase.
- R8: `done_o` is 0 during loading. It goes to 1 when the high phase of the final pulse ends. It stays at 1, with `cfg_clk_o` and `out_valid_o` at 0, until a program request arrives.
- R9: A program request in any state returns the loader to the init phase in the next cycle. The next load starts again from the first bit.
- R10: A length of 0 in a supported mode goes straight from init to done, with no clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode pins: 000 serial, 011 byte-wide |
| prog_req_i | input | 1 | Program request; restarts from the init phase |
| bit_len_i | input | LEN_W | Bitstream length in bits |
| din_i | input | DATA_W | Data from the memory chain; bit 0 in serial mode |
| cfg_clk_o | output | 1 | Configuration clock to the memories |
| init_o | output | 1 | Memory address reset, active high |
| done_o | output | 1 | Load complete; drives the memory chip enable |
| err_o | output | 1 | Unsupported mode selected |
| out_valid_o | output | 1 | One-cycle strobe for each captured bit or byte |
| out_data_o | output | DATA_W | Captured bit (in bit 0) or byte |

## Verification
The hardest situation to reach is a program request that lands partway through a load, in either phase of the configuration clock. The loader must then cut the clock, reset the memory address and start counting again from zero. The bench drives a behavioural memory whose address follows `cfg_clk_o` and `init_o`. It waits until a set number of pulses have been received, then raises the request. It then checks that the next load delivers the full length starting from address 0. Odd byte-mode lengths and a zero length exercise the rounding and the direct path from init to done.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_LOAD,
    ST_DONE,
    ST_ERROR
  } ld_state_e;

  localparam logic [2:0] MODE_SERIAL = 3'b000;
  localparam logic [2:0] MODE_BYTE   = 3'b011;
endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int DIV_HALF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic cfg_clk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == CNT_LAST);
  assign rise_o = wrap && !clk_q;
  assign fall_o = wrap && clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cfg_clk_o = clk_q;
endmodule

// File: rtl/cfg_pulse_counter.sv
module cfg_pulse_counter #(
  parameter int LEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] target_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  // high while the next increment is the final pulse
  assign last_o = (cnt_q == target_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_capture.sv
module cfg_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= take_i;
      if (take_i) data_o <= wide_i ? din_i : {{(DATA_W-1){1'b0}}, din_i[0]};
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int LEN_W    = 24,
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 3,
  parameter int INIT_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              prog_req_i,
  input  logic [LEN_W-1:0]  bit_len_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              cfg_clk_o,
  output logic              init_o,
  output logic              done_o,
  output logic              err_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int INIT_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYC - 1);

  ld_state_e         state_q, state_d;
  logic [INIT_W-1:0] init_cnt_q;
  logic [LEN_W-1:0]  tgt_q, tgt_c;
  logic [LEN_W:0]    bytes_c;
  logic              wide_q, wide_c, mode_ok;
  logic              fin_q;
  logic              run, rise, fall, last;

  assign wide_c  = (mode_i == MODE_BYTE);
  assign mode_ok = (mode_i == MODE_SERIAL) || wide_c;
  assign bytes_c = ({1'b0, bit_len_i} + (LEN_W+1)'(DATA_W - 1)) / (LEN_W+1)'(DATA_W);
  assign tgt_c   = wide_c ? bytes_c[LEN_W-1:0] : bit_len_i;

  // clock stops on the same edge a request aborts a load
  assign run = (state_q == ST_LOAD) && !prog_req_i;

  cfg_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .cfg_clk_o (cfg_clk_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  cfg_pulse_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_LOAD),
    .inc_i    (rise),
    .target_i (tgt_q),
    .last_o   (last)
  );

  cfg_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (rise),
    .wide_i  (wide_q),
    .din_i   (din_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = ST_INIT;
      ST_INIT:
        if (init_cnt_q == INIT_LAST) begin
          if (!mode_ok)           state_d = ST_ERROR;
          else if (tgt_c == '0)   state_d = ST_DONE;
          else                    state_d = ST_LOAD;
        end
      ST_LOAD: if (fall && fin_q) state_d = ST_DONE;
      default: state_d = state_q;
    endcase
    if (prog_req_i) state_d = ST_INIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      init_cnt_q <= '0;
      tgt_q      <= '0;
      wide_q     <= 1'b0;
      fin_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_INIT || prog_req_i) init_cnt_q <= '0;
      else if (init_cnt_q != INIT_LAST)     init_cnt_q <= init_cnt_q + 1'b1;
      if (state_q == ST_INIT) begin
        tgt_q  <= tgt_c;
        wide_q <= wide_c;
      end
      if (state_q != ST_LOAD)  fin_q <= 1'b0;
      else if (rise && last)   fin_q <= 1'b1;
    end
  end

  assign init_o = (state_q == ST_IDLE) || (state_q == ST_INIT);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERROR);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int DIV_HALF = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic prog_req_i,
  input logic cfg_clk_o,
  input logic init_o,
  input logic done_o,
  input logic err_o,
  input logic out_valid_o
);
  logic       prev_q;
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= 8'd1;
    end else begin
      prev_q <= cfg_clk_o;
      if (cfg_clk_o != prev_q) run_q <= 8'd1;
      else if (run_q != 8'hFF) run_q <= run_q + 8'd1;
    end
  end

  always_comb begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (init_o && !done_o && !err_o && !cfg_clk_o && !out_valid_o);
    end
  end

  assert_phase_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_clk_o != prev_q) && !init_o) |-> (run_q >= 8'(DIV_HALF)));

  assert_init_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> !cfg_clk_o);

  assert_err_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!done_o && !init_o && !cfg_clk_o));

  assert_valid_on_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $rose(cfg_clk_o));

  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cfg_clk_o && !out_valid_o && !init_o));

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !prog_req_i) |=> done_o);

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_i |=> (init_o && !done_o && !err_o));
endmodule

bind cfg_loader cfg_loader_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .prog_req_i  (prog_req_i),
  .cfg_clk_o   (cfg_clk_o),
  .init_o      (init_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .out_valid_o (out_valid_o)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  localparam int LEN_W = 24, DATA_W = 8, DIV_HALF = 3, INIT_CYC = 8;
  localparam int WD_CYC = 150000;

  logic clk = 1'b0, rst_ni = 1'b0, prog_req = 1'b0, tb_wide = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [LEN_W-1:0] bit_len = 24'd20;
  logic [DATA_W-1:0] din;
  logic cfg_clk, init, done, err, out_valid;
  logic [DATA_W-1:0] out_data;

  int n_chk = 0, n_bad = 0, cyc = 0, addr = 0;
  int pulses = 0, valids = 0, data_bad = 0, phase_bad = 0, done_clk = 0, idx = 0, run = 1;
  logic prev_clk = 1'b0;

  always #5 clk = ~clk;

  cfg_loader #(.LEN_W(LEN_W), .DATA_W(DATA_W), .DIV_HALF(DIV_HALF), .INIT_CYC(INIT_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .prog_req_i(prog_req), .bit_len_i(bit_len),
    .din_i(din), .cfg_clk_o(cfg_clk), .init_o(init), .done_o(done), .err_o(err),
    .out_valid_o(out_valid), .out_data_o(out_data));

  function automatic logic [7:0] mem_at(int a, logic w);
    logic [7:0] b = 8'((a * 29 + 11) ^ (a >> 3));
    return w ? b : {7'b0, b[0] ^ b[3]};
  endfunction

  // memory chain model: address cleared by init, advanced by each clock rise
  always @(posedge cfg_clk or posedge init)
    if (init) addr <= 0; else addr <= addr + 1;
  assign din = mem_at(addr, tb_wide);

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cfg_clk != prev_clk) begin
      if (!init && run < DIV_HALF && cyc > 2) phase_bad = phase_bad + 1;
      if (cfg_clk) pulses = pulses + 1;
      run = 1;
    end else run = run + 1;
    prev_clk = cfg_clk;
    if (done && cfg_clk) done_clk = done_clk + 1;
    if (init) idx = 0;
    else if (out_valid) begin
      valids = valids + 1;
      if (out_data != mem_at(idx, tb_wide)) data_bad = data_bad + 1;
      idx = idx + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) if (cyc >= WD_CYC) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_CYC);
    summary();
  end

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim && !done && !err; i++) @(negedge clk);
  endtask

  task automatic request(input logic [2:0] m, input int len);
    mode = m; bit_len = LEN_W'(len); tb_wide = (m == 3'b011);
    prog_req = 1'b1;
    repeat (2) @(negedge clk);
    prog_req = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(init && !done && !err && !cfg_clk && !out_valid, "R1 reset outputs", {init, done, err, cfg_clk, out_valid}, 5'b10000);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_serial();
    int p0 = pulses, v0 = valids, d0 = data_bad, hi = 0, sawlo = 0;
    for (int i = 0; i < INIT_CYC && init; i++) begin hi++; @(negedge clk); end
    check(hi >= INIT_CYC - 1, "R3 init after reset", hi, INIT_CYC);
    wait_end(2000);
    check(done && !err, "R8 done after serial load", done, 1);
    check(pulses - p0 == 20, "R7 serial pulse count", pulses - p0, 20);
    check(valids - v0 == 20 && data_bad == d0, "R5 serial data", data_bad - d0, 0);
    p0 = pulses;
    repeat (30) @(negedge clk);
    check(done && pulses == p0 && !cfg_clk, "R8 done holds, clock idle", pulses - p0, 0);
  endtask

  task automatic t_byte();
    int p0, v0, d0;
    request(3'b011, 44);
    p0 = pulses; v0 = valids; d0 = data_bad;
    check(init && !done, "R9 request reenters init", init, 1);
    wait_end(2000);
    check(done, "R8 done after byte load", done, 1);
    check(pulses - p0 == 6, "R6 byte pulse count rounded", pulses - p0, 6);
    check(valids - v0 == 6 && data_bad == d0, "R6 byte data", data_bad - d0, 0);
  endtask

  task automatic t_bad_mode();
    int p0;
    request(3'b101, 16);
    p0 = pulses;
    wait_end(200);
    repeat (20) @(negedge clk);
    check(err && !done && !init, "R2 unsupported mode error", {err, done, init}, 3'b100);
    check(pulses == p0, "R2 no clock in error", pulses - p0, 0);
  endtask

  task automatic t_restart();
    int p0, v0, d0, k = 0, hi = 0;
    request(3'b000, 40);
    p0 = pulses;
    for (int i = 0; i < 2000 && pulses - p0 < 10; i++) @(negedge clk);
    check(!done && !init && !err, "R8 done low mid load", done, 0);
    prog_req = 1'b1;
    repeat (4) begin @(negedge clk); k += init; end
    check(k == 4 && !cfg_clk, "R3 init held by request", k, 4);
    prog_req = 1'b0;
    p0 = pulses; v0 = valids; d0 = data_bad;
    while (init && hi < 100) begin hi++; @(negedge clk); end
    check(hi >= INIT_CYC - 1, "R3 init length after request", hi, INIT_CYC);
    wait_end(3000);
    check(pulses - p0 == 40, "R9 full restart count", pulses - p0, 40);
    check(valids - v0 == 40 && data_bad == d0, "R9 restart data from address 0", data_bad - d0, 0);
  endtask

  task automatic t_zero();
    int p0;
    request(3'b000, 0);
    p0 = pulses;
    wait_end(200);
    check(done && pulses == p0, "R10 zero length done", pulses - p0, 0);
    request(3'b011, 1);
    p0 = pulses;
    wait_end(500);
    check(done && pulses - p0 == 1, "R6 single byte for 1 bit", pulses - p0, 1);
  endtask

  initial begin
    t_reset();
    t_serial();
    t_byte();
    t_bad_mode();
    t_restart();
    t_zero();
    check(phase_bad == 0, "R4 phase width", phase_bad, 0);
    check(done_clk == 0, "R8 clock while done", done_clk, 0);
    summary();
  end
endmodule